// File: doc/BRIEF.md
# Backup Cell Selector with Isolation

This clocked controller decides which of two backup energy cells feeds an external static memory once the main supply has collapsed. It also decides whether backup is withheld altogether, so that the cells are not drained when the memory holds nothing worth keeping. Every input is a digital flag from analog circuitry that lies outside the block: the comparators that watch the supply against two thresholds, the validity check on cell 1, the presence detector on cell 2, the chip-enable level and a pulse that marks a battery being attached. The outputs drive the external power switches.

Supply state moves through three phases: powered, failing and on backup. In the failing phase the supply is below the power-fail threshold but still above the switch-over threshold. Backup is on only in the third phase. Cell 1 is preferred, and cell 2 takes over whenever cell 1 is not valid. There are two ways into isolation. One is a battery-attach pulse. The other is a chip-enable-low signature, held for a minimum number of cycles across the whole failing phase of a power-down. Once isolated, backup is reconnected only after the supply has been restored and then lost again.

Top module: `bkup_cell_sel`

## Requirements
- R1: After reset, sel_cell1, sel_cell2 and no_backup are 0, and isolated equals the ISO_RST parameter (default 0).
- R2: While the supply is not below the switch-over threshold (vdd_below_so = 0), sel_cell1, sel_cell2 and no_backup are all 0. This holds in the failing phase (vdd_below_pf = 1, vdd_below_so = 0) as well.
- R3: On backup (vdd_below_so = 1) and not isolated, cell1_ok = 1 gives sel_cell1 = 1 and sel_cell2 = 0.
- R4: On backup and not isolated, cell1_ok = 0 with cell2_present = 1 gives sel_cell2 = 1 and sel_cell1 = 0. This includes cell 1 becoming invalid while on backup. The two selects are never high together.
- R5: On backup and not isolated, cell1_ok = 0 with cell2_present = 0 gives both selects 0 and no_backup = 1. no_backup is 0 whenever a cell is selected.
- R6: A one-cycle batt_attach = 1 pulse in any phase sets isolated = 1. While isolated, both selects and no_backup are 0.
- R7: ce_low = 1 means chip-enable is at its low level. If ce_low = 1 on every cycle of a failing phase lasting at least MIN_LOW_CYC cycles, isolated becomes 1 when the supply then drops below the switch-over threshold.
- R8: The signature does not isolate in three cases: a single ce_low = 0 cycle anywhere in the failing phase, a failing phase shorter than MIN_LOW_CYC cycles, or a drop straight from powered to backup with no failing phase.
- R9: An isolated block stays isolated while the supply returns to powered. It clears isolated, and selects a cell again, on the next entry into backup that carries no valid signature.
- R10: If a valid signature arrives in the same cycle as the re-entry into backup that would reconnect, isolation wins and isolated stays 1.
- R11: Outputs follow an input change exactly SYNC_STAGES+1 clock cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cell1_ok | input | 1 | Cell 1 is above its valid threshold |
| cell2_present | input | 1 | Cell 2 is fitted |
| vdd_below_pf | input | 1 | Supply below the power-fail threshold |
| vdd_below_so | input | 1 | Supply below the switch-over threshold |
| ce_low | input | 1 | Chip-enable input is at its low level |
| batt_attach | input | 1 | One-cycle pulse when a battery is attached |
| sel_cell1 | output | 1 | Connect cell 1 to the memory supply |
| sel_cell2 | output | 1 | Connect cell 2 to the memory supply |
| isolated | output | 1 | Backup withheld from both cells |
| no_backup | output | 1 | On backup, not isolated, and no usable cell |

## Verification
The reconnect event and the signature-driven isolation can fall in the same cycle, because both are triggered by the one edge where the supply enters backup. The bench provokes this in two steps. It first isolates the block and restores the supply, which re-arms reconnection. It then runs a qualifying chip-enable-low failing phase before the next drop. The result is judged by isolated staying high with both selects low. A failed signature run into the same armed state is the contrast: it must reconnect, and the bench checks that it does.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
   typedef enum logic [1:0] {
      PH_OK     = 2'd0,
      PH_FAIL   = 2'd1,
      PH_BACKUP = 2'd2
   } phase_e;
endpackage

// File: rtl/bcs_sync.sv
module bcs_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 1 || STAGES > 4) begin : g_bad_stages
      $error("bcs_sync: STAGES must be within 1..4");
   end

   logic [STAGES-1:0][W-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= '0;
            else        chain[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= '0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/bcs_phase_sig.sv
module bcs_phase_sig
   import bcs_pkg::*;
#(
   parameter int MIN_LOW_CYC = 70
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   below_pf,
   input  logic   below_so,
   input  logic   ce_low,
   output phase_e ph_q,
   output phase_e ph_nxt,
   output logic   enter_backup,
   output logic   enter_ok,
   output logic   sig_hit
);
   localparam int CW = $clog2(MIN_LOW_CYC + 1);
   localparam logic [CW-1:0] CNT_TOP = CW'(MIN_LOW_CYC);

   if (MIN_LOW_CYC < 1) begin : g_bad_min
      $error("bcs_phase_sig: MIN_LOW_CYC must be at least 1");
   end

   logic [CW-1:0] low_cnt_q;
   logic          spoiled_q;

   // The switch-over comparator dominates: below it means backup.
   always_comb begin
      if (below_so)      ph_nxt = PH_BACKUP;
      else if (below_pf) ph_nxt = PH_FAIL;
      else               ph_nxt = PH_OK;
   end

   assign enter_backup = (ph_nxt == PH_BACKUP) && (ph_q != PH_BACKUP);
   assign enter_ok     = (ph_nxt == PH_OK) && (ph_q != PH_OK);

   // A valid signature needs a full failing phase seen just before the drop.
   assign sig_hit = enter_backup && (ph_q == PH_FAIL) && !spoiled_q
                    && (low_cnt_q >= CNT_TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q <= PH_OK;
      end else begin
         ph_q <= ph_nxt;
      end
   end

   // Window counter: counts low chip-enable cycles inside the failing
   // phase, restarts on any high cycle and remembers that one occurred.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt_q <= '0;
         spoiled_q <= 1'b0;
      end else if (ph_nxt == PH_FAIL) begin
         if (ph_q != PH_FAIL) begin
            low_cnt_q <= ce_low ? CW'(1) : '0;
            spoiled_q <= !ce_low;
         end else if (ce_low) begin
            if (low_cnt_q != CNT_TOP) low_cnt_q <= low_cnt_q + CW'(1);
         end else begin
            low_cnt_q <= '0;
            spoiled_q <= 1'b1;
         end
      end else begin
         low_cnt_q <= '0;
         spoiled_q <= 1'b0;
      end
   end
endmodule

// File: rtl/bcs_iso_route.sv
module bcs_iso_route
   import bcs_pkg::*;
#(
   parameter bit CELL2_EN = 1'b1,
   parameter bit ISO_RST  = 1'b0
) (
   input  logic   clk,
   input  logic   rst_n,
   input  phase_e ph_nxt,
   input  logic   enter_backup,
   input  logic   enter_ok,
   input  logic   sig_hit,
   input  logic   attach,
   input  logic   c1_ok,
   input  logic   c2_here,
   output logic   isolated,
   output logic   sel1,
   output logic   sel2,
   output logic   no_bk
);
   logic iso_q, armed_q;
   logic iso_nxt, armed_nxt;
   logic c2_use;
   logic on_bk;

   if (CELL2_EN) begin : g_cell2
      assign c2_use = c2_here;
   end else begin : g_cell1_only
      logic c2_ignored;
      assign c2_ignored = c2_here;
      assign c2_use     = 1'b0 & c2_ignored;
   end

   // Isolation wins over reconnect when both land on the same edge.
   always_comb begin
      iso_nxt   = iso_q;
      armed_nxt = armed_q;
      if (attach || sig_hit) begin
         iso_nxt   = 1'b1;
         armed_nxt = 1'b0;
      end else if (iso_q && armed_q && enter_backup) begin
         iso_nxt   = 1'b0;
         armed_nxt = 1'b0;
      end else if (iso_q && enter_ok) begin
         armed_nxt = 1'b1;
      end
   end

   assign on_bk = (ph_nxt == PH_BACKUP) && !iso_nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iso_q   <= ISO_RST;
         armed_q <= 1'b0;
         sel1    <= 1'b0;
         sel2    <= 1'b0;
         no_bk   <= 1'b0;
      end else begin
         iso_q   <= iso_nxt;
         armed_q <= armed_nxt;
         sel1    <= on_bk && c1_ok;
         sel2    <= on_bk && !c1_ok && c2_use;
         no_bk   <= on_bk && !c1_ok && !c2_use;
      end
   end

   assign isolated = iso_q;
endmodule

// File: rtl/bkup_cell_sel.sv
module bkup_cell_sel
   import bcs_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int MIN_LOW_CYC = 70,
   parameter bit CELL2_EN    = 1'b1,
   parameter bit ISO_RST     = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cell1_ok,
   input  logic cell2_present,
   input  logic vdd_below_pf,
   input  logic vdd_below_so,
   input  logic ce_low,
   input  logic batt_attach,
   output logic sel_cell1,
   output logic sel_cell2,
   output logic isolated,
   output logic no_backup
);
   localparam int NIN = 6;

   logic [NIN-1:0] raw_in, syn_in;
   logic s_c1, s_c2, s_pf, s_so, s_ce, s_attach;
   phase_e ph_q, ph_nxt;
   logic enter_backup, enter_ok, sig_hit;

   assign raw_in = {batt_attach, ce_low, vdd_below_so, vdd_below_pf,
                    cell2_present, cell1_ok};

   bcs_sync #(.W(NIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
   );

   assign {s_attach, s_ce, s_so, s_pf, s_c2, s_c1} = syn_in;

   bcs_phase_sig #(.MIN_LOW_CYC(MIN_LOW_CYC)) u_phase (
      .clk(clk), .rst_n(rst_n), .below_pf(s_pf), .below_so(s_so),
      .ce_low(s_ce), .ph_q(ph_q), .ph_nxt(ph_nxt),
      .enter_backup(enter_backup), .enter_ok(enter_ok), .sig_hit(sig_hit)
   );

   bcs_iso_route #(.CELL2_EN(CELL2_EN), .ISO_RST(ISO_RST)) u_route (
      .clk(clk), .rst_n(rst_n), .ph_nxt(ph_nxt),
      .enter_backup(enter_backup), .enter_ok(enter_ok), .sig_hit(sig_hit),
      .attach(s_attach), .c1_ok(s_c1), .c2_here(s_c2),
      .isolated(isolated), .sel1(sel_cell1), .sel2(sel_cell2),
      .no_bk(no_backup)
   );
endmodule

// File: rtl/bcs_chk.sv
module bcs_chk
   import bcs_pkg::*;
(
   input logic   clk,
   input logic   rst_n,
   input logic   sel1,
   input logic   sel2,
   input logic   iso,
   input logic   nob,
   input phase_e ph,
   input logic   c1,
   input logic   att
);
   AST_ONE_CELL: assert property (@(posedge clk) disable iff (!rst_n)
      !(sel1 && sel2)); // R4

   AST_POWERED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ph != PH_BACKUP) |-> (!sel1 && !sel2 && !nob)); // R2

   AST_ISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      iso |-> (!sel1 && !sel2 && !nob)); // R6

   AST_PREFER_C1: assert property (@(posedge clk) disable iff (!rst_n)
      sel2 |-> !$past(c1)); // R4

   AST_NOBK_NO_C1: assert property (@(posedge clk) disable iff (!rst_n)
      nob |-> (!$past(c1) && !sel1 && !sel2)); // R5

   AST_ATTACH_ISO: assert property (@(posedge clk) disable iff (!rst_n)
      att |=> iso); // R6

   AST_RECONNECT_ON_BK: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(iso) |-> (ph == PH_BACKUP)); // R9
endmodule

bind bkup_cell_sel bcs_chk u_chk (
   .clk(clk), .rst_n(rst_n), .sel1(sel_cell1), .sel2(sel_cell2),
   .iso(isolated), .nob(no_backup), .ph(ph_q), .c1(s_c1), .att(s_attach)
);

// File: tb/bkup_cell_sel_tb.sv
module bkup_cell_sel_tb;
   localparam int CLK_P = 10;
   localparam int SYNC  = 2;
   localparam int MINC  = 4;
   localparam int LAT   = SYNC + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cell1_ok = 1'b0, cell2_present = 1'b0;
   logic vdd_below_pf = 1'b0, vdd_below_so = 1'b0;
   logic ce_low = 1'b0, batt_attach = 1'b0;
   logic sel_cell1, sel_cell2, isolated, no_backup;
   int n_chk = 0, n_bad = 0;

   always #(CLK_P/2) clk = ~clk;

   bkup_cell_sel #(.SYNC_STAGES(SYNC), .MIN_LOW_CYC(MINC),
                   .CELL2_EN(1'b1), .ISO_RST(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .cell1_ok(cell1_ok),
      .cell2_present(cell2_present), .vdd_below_pf(vdd_below_pf),
      .vdd_below_so(vdd_below_so), .ce_low(ce_low),
      .batt_attach(batt_attach), .sel_cell1(sel_cell1),
      .sel_cell2(sel_cell2), .isolated(isolated), .no_backup(no_backup)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
      end
   endtask

   task automatic supply(input logic pf, input logic so);
      vdd_below_pf = pf;
      vdd_below_so = so;
   endtask

   // Failing phase of len cycles; ce high on cycle bad (negative: never).
   task automatic power_down(input int len, input int bad);
      if (len == 0) begin
         supply(1'b1, 1'b1);
      end else begin
         supply(1'b1, 1'b0);
         for (int i = 0; i < len; i++) begin
            ce_low = (i != bad);
            tick(1);
         end
         supply(1'b1, 1'b1);
      end
      ce_low = 1'b0;
      tick(LAT);
   endtask

   initial begin
      #(CLK_P * 50000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      tick(3);
      // R1 reset state
      chk("R1 sel_cell1", sel_cell1, 1'b0);
      chk("R1 sel_cell2", sel_cell2, 1'b0);
      chk("R1 no_backup", no_backup, 1'b0);
      chk("R1 isolated", isolated, 1'b0);
      rst_n = 1'b1;
      tick(LAT);

      // Sweep cell flags through all three phases
      for (int c = 0; c < 4; c++) begin
         logic e1, e2;
         e1 = c[0];
         e2 = c[1];
         cell1_ok = e1;
         cell2_present = e2;
         supply(1'b0, 1'b0);
         tick(LAT);
         chk("R2 powered sel1", sel_cell1, 1'b0);
         chk("R2 powered sel2", sel_cell2, 1'b0);
         chk("R2 powered nob", no_backup, 1'b0);
         supply(1'b1, 1'b0);
         tick(LAT);
         chk("R2 failing sel1", sel_cell1, 1'b0);
         chk("R2 failing sel2", sel_cell2, 1'b0);
         chk("R2 failing nob", no_backup, 1'b0);
         supply(1'b1, 1'b1);
         tick(LAT);
         chk("R3 backup sel1", sel_cell1, e1);
         chk("R4 backup sel2", sel_cell2, !e1 && e2);
         chk("R5 backup nob", no_backup, !e1 && !e2);
         chk("R8 no signature iso", isolated, 1'b0);
         if (e1) begin
            cell1_ok = 1'b0;
            tick(LAT);
            chk("R4 c1 drop sel1", sel_cell1, 1'b0);
            chk("R4 c1 drop sel2", sel_cell2, e2);
            chk("R5 c1 drop nob", no_backup, !e2);
         end
         supply(1'b0, 1'b0);
         tick(LAT);
      end

      // R11 latency
      cell1_ok = 1'b1;
      cell2_present = 1'b1;
      supply(1'b1, 1'b1);
      tick(LAT - 1);
      chk("R11 before latency", sel_cell1, 1'b0);
      tick(1);
      chk("R11 at latency", sel_cell1, 1'b1);

      // R6 attach while on backup
      batt_attach = 1'b1;
      tick(1);
      batt_attach = 1'b0;
      tick(LAT - 1);
      chk("R6 attach on backup iso", isolated, 1'b1);
      chk("R6 attach on backup sel1", sel_cell1, 1'b0);
      // R9 restore then lose supply
      supply(1'b0, 1'b0);
      tick(LAT);
      chk("R9 held through restore", isolated, 1'b1);
      power_down(1, -1);
      chk("R9 reconnect iso", isolated, 1'b0);
      chk("R9 reconnect sel1", sel_cell1, 1'b1);
      supply(1'b0, 1'b0);
      tick(LAT);

      // R6 attach while powered: no reconnect on the first drop
      batt_attach = 1'b1;
      tick(1);
      batt_attach = 1'b0;
      tick(LAT - 1);
      chk("R6 attach powered iso", isolated, 1'b1);
      power_down(2, -1);
      chk("R6 first drop stays iso", isolated, 1'b1);
      chk("R6 first drop sel1", sel_cell1, 1'b0);
      supply(1'b0, 1'b0);
      tick(LAT);
      power_down(2, -1);
      chk("R9 second drop reconnect", isolated, 1'b0);
      supply(1'b0, 1'b0);
      tick(LAT);

      // R7/R8 signature length sweep and spoil position sweep
      for (int len = 0; len <= MINC + 2; len++) begin
         for (int bad = -1; bad < len; bad++) begin
            logic exp_iso;
            exp_iso = (len >= MINC) && (bad < 0);
            power_down(len, bad);
            if (exp_iso) chk("R7 signature iso", isolated, 1'b1);
            else         chk("R8 spoiled/short iso", isolated, 1'b0);
            chk("R7 R8 sel1", sel_cell1, !exp_iso);
            supply(1'b0, 1'b0);
            tick(LAT);
            chk("R9 iso kept powered", isolated, exp_iso);
            power_down(1, -1);
            chk("R9 rearm reconnect", isolated, 1'b0);
            supply(1'b0, 1'b0);
            tick(LAT);
         end
      end

      // R10 signature on the re-entry that would reconnect
      power_down(MINC, -1);
      chk("R10 setup iso", isolated, 1'b1);
      supply(1'b0, 1'b0);
      tick(LAT);
      power_down(MINC + 1, -1);
      chk("R10 signature beats reconnect", isolated, 1'b1);
      chk("R10 sel1 low", sel_cell1, 1'b0);
      supply(1'b0, 1'b0);
      tick(LAT);
      power_down(MINC - 1, -1);
      chk("R10 short window reconnects", isolated, 1'b0);
      chk("R10 sel1 back", sel_cell1, 1'b1);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule